// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block walks one DMA channel through a transfer block and produces its addresses. A block is a number of frames, and each frame is a number of elements. For every element the sequencer offers one pair of addresses: a read (source) address and a write (destination) address. The pair is sent on a valid/ready stream. Each side has its own addressing mode and its own signed element and frame index offsets. The element width is 1, 2 or 4 bytes. An external memory engine takes the address pairs and performs the bus traffic. The sequencer itself moves no data.

Pacing has two forms. In free-running mode, selected by a sync selector of zero, all elements of the block are offered back to back. In synchronized mode each sync request grants a unit of credit: one element, one frame, the whole block, or one packet. A request that arrives while earlier credit is still outstanding is dropped and reported. One-cycle event pulses mark the half-frame point, the end of a frame, the start of the last frame and the end of the block.

A control level `start_i` runs the block. A rising edge while idle latches the whole configuration and launches the block. Lowering `start_i` aborts a running block. Stream rules: once `out_valid_o` is high with `out_ready_i` low, the pair is held unchanged and stays offered. The only exception is an abort. A pair is consumed at each clock edge where valid and ready are both high.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, `out_valid_o`, `busy_o` and all event outputs are low.
- R2: A rising edge of `start_i` while idle latches every configuration input. `busy_o` is high one cycle later. In free-running mode (`sync_sel_i` = 0) the first pair is offered in that same cycle, at the two start addresses. In free-running mode `sync_req_i` has no effect and never raises `ev_drop_o`.
- R3: Exactly elem_cnt × frame_cnt pairs are accepted. In the cycle after the last pair is accepted, `ev_block_o` pulses and `busy_o` and `out_valid_o` are low.
- R4: Mode code 0 (constant) keeps the address fixed. Mode code 1 (post-increment) adds the element size after each element. The element size comes from `dtype_i`: 0 gives 1 byte, 1 gives 2 bytes, 2 and 3 give 4 bytes.
- R5: Mode code 2 (single-index) adds the sign-extended 16-bit element index after each element. Mode code 3 (double-index) does the same, except that after the last element of a frame it adds the sign-extended frame index instead.
- R6: While `out_valid_o` is high, `out_ready_i` is low and `start_i` stays high, the next cycle still has `out_valid_o` high with both addresses unchanged.
- R7: If elem_cnt or frame_cnt is zero, launching issues no pair. In the cycle after the launch edge, `ev_block_o` pulses and `busy_o` stays low.
- R8: Each event pulses in the cycle after the accepted pair that causes it. `ev_half_o` fires when the pairs accepted within the frame reach floor(elem_cnt/2), provided that is at least 1. `ev_frame_o` fires on the last element of each frame. `ev_last_frame_o` fires on the first element of the final frame.
- R9: In synchronized mode, `out_valid_o` is low while no credit remains. A sync request with no credit left grants a unit, capped at the elements still remaining. The unit is the whole block if block sync is set, otherwise one frame (elem_cnt) if frame sync is set, otherwise one element. Requests while idle are ignored.
- R10: In packet mode the unit is a packet, which takes precedence over block and frame sync. The packet size is the unsigned source frame index when syncing on the source, and the destination frame index otherwise. A size of 0 acts as 1.
- R11: A sync request in synchronized mode while credit is still outstanding leaves the credit unchanged and pulses `ev_drop_o` in the next cycle.
- R12: Lowering `start_i` while busy clears `busy_o` and `out_valid_o` at the next edge. No further pairs or events follow. A later launch starts again from the start addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Run level; a rising edge launches, low aborts |
| src_base_i | input | 32 | Source start address |
| dst_base_i | input | 32 | Destination start address |
| elem_cnt_i | input | 24 | Elements per frame |
| frame_cnt_i | input | 16 | Frames per block |
| dtype_i | input | 2 | Element size code |
| src_mode_i | input | 2 | Source addressing mode |
| dst_mode_i | input | 2 | Destination addressing mode |
| src_eidx_i | input | 16 | Source element index (signed) |
| dst_eidx_i | input | 16 | Destination element index (signed) |
| src_fidx_i | input | 16 | Source frame index (signed) / packet size |
| dst_fidx_i | input | 16 | Destination frame index (signed) / packet size |
| pkt_mode_i | input | 1 | Packet pacing |
| sync_sel_i | input | 7 | Trigger selector; 0 means free-running |
| frame_sync_i | input | 1 | One request moves a frame |
| block_sync_i | input | 1 | One request moves the block |
| sync_on_src_i | input | 1 | Trigger tied to the source side |
| sync_req_i | input | 1 | Sync request pulse |
| out_valid_o | output | 1 | Address pair offered |
| out_ready_i | input | 1 | Consumer accepts the pair |
| rd_addr_o | output | 32 | Read address |
| wr_addr_o | output | 32 | Write address |
| busy_o | output | 1 | Block in progress |
| ev_half_o | output | 1 | Half-frame event |
| ev_frame_o | output | 1 | Frame-end event |
| ev_last_frame_o | output | 1 | Last-frame-start event |
| ev_block_o | output | 1 | Block-end event |
| ev_drop_o | output | 1 | Dropped sync request |

## Verification
The hardest situation to reach is a sync request that lands while credit is partly used, in the same cycle as a held or accepted pair. Reaching it needs back-pressure, pacing and request timing to line up. The stimulus raises requests on about a third of all cycles and withholds ready on about a quarter. It does this across many random configurations and all pacing kinds, so both drops and grants happen in the middle of units and across frame boundaries. A reference model in the bench tracks the credit, the expected address of element n in closed form and the expected events, and compares them every cycle. Directed blocks cover zero counts, packet size zero and an abort followed by a fresh launch.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    AM_CONST = 2'd0,
    AM_INC   = 2'd1,
    AM_SIDX  = 2'd2,
    AM_DIDX  = 2'd3
  } addr_mode_e;

  function automatic logic [2:0] elem_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_side.sv
module dma_addr_side
  import dma_seq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IXW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  base,
  input  addr_mode_e     mode,
  input  logic [2:0]     esize,
  input  logic [IXW-1:0] eidx,
  input  logic [IXW-1:0] fidx,
  input  logic           step,
  input  logic           frame_end,
  output logic [AW-1:0]  addr
);
  localparam int PADW = AW - IXW;

  logic [AW-1:0] e_off, f_off, next_addr;

  assign e_off = {{PADW{eidx[IXW-1]}}, eidx};
  assign f_off = {{PADW{fidx[IXW-1]}}, fidx};

  always_comb begin
    case (mode)
      AM_CONST: next_addr = addr;
      AM_INC:   next_addr = addr + AW'(esize);
      AM_SIDX:  next_addr = addr + e_off;
      default:  next_addr = frame_end ? addr + f_off : addr + e_off;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= base;
    else if (step) addr <= next_addr;
  end

  AST_CONST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_CONST && step && !load) |=> $stable(addr)); // R4
endmodule

// File: rtl/dma_pacer.sv
module dma_pacer #(
  parameter int TW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          busy,
  input  logic          free,
  input  logic          sync_req,
  input  logic          step,
  input  logic [TW-1:0] unit,
  input  logic [TW-1:0] left,
  output logic          credit,
  output logic          drop
);
  logic [TW-1:0] pend;
  logic          paced;

  assign paced  = busy && !free;
  assign credit = free || (pend != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      drop <= 1'b0;
    end else begin
      drop <= paced && sync_req && (pend != '0) && !clear;
      if (clear)
        pend <= '0;
      else if (paced && sync_req && pend == '0)
        pend <= (unit < left) ? unit : left;
      else if (paced && step)
        pend <= pend - TW'(1);
    end
  end

  AST_GRANT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (paced && sync_req && pend == '0 && !clear) |=> (pend != '0)); // R9
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (paced && sync_req && pend != '0 && !step && !clear) |=> $stable(pend)); // R11
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int ECW = 24,
  parameter int FCW = 16,
  parameter int IXW = 16,
  parameter int SSW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [AW-1:0]  src_base_i,
  input  logic [AW-1:0]  dst_base_i,
  input  logic [ECW-1:0] elem_cnt_i,
  input  logic [FCW-1:0] frame_cnt_i,
  input  logic [1:0]     dtype_i,
  input  logic [1:0]     src_mode_i,
  input  logic [1:0]     dst_mode_i,
  input  logic [IXW-1:0] src_eidx_i,
  input  logic [IXW-1:0] dst_eidx_i,
  input  logic [IXW-1:0] src_fidx_i,
  input  logic [IXW-1:0] dst_fidx_i,
  input  logic           pkt_mode_i,
  input  logic [SSW-1:0] sync_sel_i,
  input  logic           frame_sync_i,
  input  logic           block_sync_i,
  input  logic           sync_on_src_i,
  input  logic           sync_req_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [AW-1:0]  rd_addr_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic           busy_o,
  output logic           ev_half_o,
  output logic           ev_frame_o,
  output logic           ev_last_frame_o,
  output logic           ev_block_o,
  output logic           ev_drop_o
);
  localparam int TW = ECW + FCW;

  logic           start_q, busy_q, launch, zero_cnt, step, credit;
  logic [ECW-1:0] ecnt_q, epos_q, half_pt;
  logic [FCW-1:0] fcnt_q, fpos_q;
  logic [TW-1:0]  left_q, unit_q, total_w, unit_w;
  logic [2:0]     esize_q;
  addr_mode_e     smode_q, dmode_q;
  logic [IXW-1:0] seidx_q, deidx_q, sfidx_q, dfidx_q, pkt_sz;
  logic           free_q, last_in_frame, last_frame;

  assign launch   = start_i && !start_q && !busy_q;
  assign zero_cnt = (elem_cnt_i == '0) || (frame_cnt_i == '0);
  assign total_w  = TW'(elem_cnt_i) * TW'(frame_cnt_i);
  assign pkt_sz   = sync_on_src_i ? src_fidx_i : dst_fidx_i;

  always_comb begin
    if (pkt_mode_i)        unit_w = (pkt_sz == '0) ? TW'(1) : TW'(pkt_sz);
    else if (block_sync_i) unit_w = total_w;
    else if (frame_sync_i) unit_w = TW'(elem_cnt_i);
    else                   unit_w = TW'(1);
  end

  assign last_in_frame = (epos_q == ecnt_q - ECW'(1));
  assign last_frame    = (fpos_q == fcnt_q - FCW'(1));
  assign half_pt       = ecnt_q >> 1;
  assign out_valid_o   = busy_q && credit;
  assign step          = out_valid_o && out_ready_i;
  assign busy_o        = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0; busy_q <= 1'b0;
      ecnt_q <= '0; fcnt_q <= '0; epos_q <= '0; fpos_q <= '0;
      left_q <= '0; unit_q <= '0; esize_q <= 3'd1; free_q <= 1'b1;
      smode_q <= AM_CONST; dmode_q <= AM_CONST;
      seidx_q <= '0; deidx_q <= '0; sfidx_q <= '0; dfidx_q <= '0;
      ev_half_o <= 1'b0; ev_frame_o <= 1'b0;
      ev_last_frame_o <= 1'b0; ev_block_o <= 1'b0;
    end else begin
      start_q         <= start_i;
      ev_half_o       <= 1'b0;
      ev_frame_o      <= 1'b0;
      ev_last_frame_o <= 1'b0;
      ev_block_o      <= 1'b0;
      if (launch) begin
        ecnt_q  <= elem_cnt_i;
        fcnt_q  <= frame_cnt_i;
        esize_q <= elem_bytes(dtype_i);
        smode_q <= addr_mode_e'(src_mode_i);
        dmode_q <= addr_mode_e'(dst_mode_i);
        seidx_q <= src_eidx_i;
        deidx_q <= dst_eidx_i;
        sfidx_q <= src_fidx_i;
        dfidx_q <= dst_fidx_i;
        free_q  <= (sync_sel_i == '0);
        unit_q  <= unit_w;
        epos_q  <= '0;
        fpos_q  <= '0;
        left_q  <= zero_cnt ? '0 : total_w;
        busy_q  <= !zero_cnt;
        ev_block_o <= zero_cnt;
      end else if (busy_q && !start_i) begin
        busy_q <= 1'b0;
      end else if (step) begin
        ev_half_o       <= (half_pt != '0) && (epos_q + ECW'(1) == half_pt);
        ev_frame_o      <= last_in_frame;
        ev_last_frame_o <= (epos_q == '0) && last_frame;
        ev_block_o      <= (left_q == TW'(1));
        if (left_q == TW'(1)) busy_q <= 1'b0;
        left_q <= left_q - TW'(1);
        if (last_in_frame) begin
          epos_q <= '0;
          fpos_q <= fpos_q + FCW'(1);
        end else begin
          epos_q <= epos_q + ECW'(1);
        end
      end
    end
  end

  dma_addr_side #(.AW(AW), .IXW(IXW)) src_side_i (
    .clk(clk), .rst_n(rst_n), .load(launch), .base(src_base_i),
    .mode(smode_q), .esize(esize_q), .eidx(seidx_q), .fidx(sfidx_q),
    .step(step), .frame_end(last_in_frame), .addr(rd_addr_o));

  dma_addr_side #(.AW(AW), .IXW(IXW)) dst_side_i (
    .clk(clk), .rst_n(rst_n), .load(launch), .base(dst_base_i),
    .mode(dmode_q), .esize(esize_q), .eidx(deidx_q), .fidx(dfidx_q),
    .step(step), .frame_end(last_in_frame), .addr(wr_addr_o));

  dma_pacer #(.TW(TW)) pacer_i (
    .clk(clk), .rst_n(rst_n), .clear(launch), .busy(busy_q),
    .free(free_q), .sync_req(sync_req_i), .step(step),
    .unit(unit_q), .left(left_q), .credit(credit), .drop(ev_drop_o));

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && start_i) |=>
      (out_valid_o && $stable(rd_addr_o) && $stable(wr_addr_o))); // R6
  AST_BLOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_block_o |-> (!busy_o && !out_valid_o)); // R3
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i) |=> (!busy_o && !out_valid_o)); // R12
  AST_EMPTY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && zero_cnt) |=> (ev_block_o && !busy_o)); // R7
endmodule

// File: tb/dma_addr_seq_tb_top.sv
module dma_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] src_base_i = '0, dst_base_i = '0;
  logic [23:0] elem_cnt_i = '0;
  logic [15:0] frame_cnt_i = '0;
  logic [1:0]  dtype_i = '0, src_mode_i = '0, dst_mode_i = '0;
  logic [15:0] src_eidx_i = '0, dst_eidx_i = '0, src_fidx_i = '0, dst_fidx_i = '0;
  logic        pkt_mode_i = 1'b0, frame_sync_i = 1'b0, block_sync_i = 1'b0;
  logic        sync_on_src_i = 1'b0, sync_req_i = 1'b0, out_ready_i = 1'b0;
  logic [6:0]  sync_sel_i = '0;
  logic        out_valid_o, busy_o, ev_half_o, ev_frame_o, ev_last_frame_o;
  logic        ev_block_o, ev_drop_o;
  logic [31:0] rd_addr_o, wr_addr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dma_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .src_base_i(src_base_i), .dst_base_i(dst_base_i),
    .elem_cnt_i(elem_cnt_i), .frame_cnt_i(frame_cnt_i), .dtype_i(dtype_i),
    .src_mode_i(src_mode_i), .dst_mode_i(dst_mode_i),
    .src_eidx_i(src_eidx_i), .dst_eidx_i(dst_eidx_i),
    .src_fidx_i(src_fidx_i), .dst_fidx_i(dst_fidx_i),
    .pkt_mode_i(pkt_mode_i), .sync_sel_i(sync_sel_i),
    .frame_sync_i(frame_sync_i), .block_sync_i(block_sync_i),
    .sync_on_src_i(sync_on_src_i), .sync_req_i(sync_req_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .rd_addr_o(rd_addr_o), .wr_addr_o(wr_addr_o), .busy_o(busy_o),
    .ev_half_o(ev_half_o), .ev_frame_o(ev_frame_o),
    .ev_last_frame_o(ev_last_frame_o), .ev_block_o(ev_block_o),
    .ev_drop_o(ev_drop_o));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int esz(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int mode,
      input int sz, input int ei, input int fi, input int ne, input int n);
    int f = n / ne;
    int e = n % ne;
    longint a;
    case (mode)
      0: a = longint'(base);
      1: a = longint'(base) + longint'(n) * sz;
      2: a = longint'(base) + longint'(n) * ei;
      default: a = longint'(base) + longint'(f) * ((ne - 1) * ei + fi) + longint'(e) * ei;
    endcase
    return a[31:0];
  endfunction

  function automatic string mtag(input int mode);
    return (mode < 2) ? "R4" : "R5";
  endfunction

  // Runs one block; abort_at >= 0 lowers start when element abort_at is next.
  task automatic run_block(input int ne, input int nf, input int dt, input int sm,
      input int dm, input int sei, input int dei, input int sfi, input int dfi,
      input bit pkt, input int ssel, input bit fs, input bit bs, input bit sos,
      input logic [31:0] sb, input logic [31:0] db, input int abort_at);
    int n = 0, left, pend = 0, unit, pk;
    bit free, hs;
    bit [4:0] xev;
    bit [4:0] aev;
    @(negedge clk);
    elem_cnt_i = 24'(ne); frame_cnt_i = 16'(nf); dtype_i = 2'(dt);
    src_mode_i = 2'(sm); dst_mode_i = 2'(dm);
    src_eidx_i = 16'(sei); dst_eidx_i = 16'(dei);
    src_fidx_i = 16'(sfi); dst_fidx_i = 16'(dfi);
    pkt_mode_i = pkt; sync_sel_i = 7'(ssel); frame_sync_i = fs;
    block_sync_i = bs; sync_on_src_i = sos;
    src_base_i = sb; dst_base_i = db;
    out_ready_i = 1'b0; sync_req_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    // configuration changes after launch must be ignored (latched, R2)
    src_base_i = ~sb; elem_cnt_i = 24'(ne + 3); src_eidx_i = ~src_eidx_i;
    if (ne == 0 || nf == 0) begin
      chk(ev_block_o == 1'b1, "R7 ev_block", ev_block_o, 1);
      chk(busy_o == 1'b0 && out_valid_o == 1'b0, "R7 busy/valid", {busy_o, out_valid_o}, 0);
      start_i = 1'b0;
      @(negedge clk);
      chk(ev_block_o == 1'b0 && out_valid_o == 1'b0, "R7 no follow-up", {ev_block_o, out_valid_o}, 0);
      return;
    end
    chk(busy_o == 1'b1, "R2 busy", busy_o, 1);
    left = ne * nf;
    free = (ssel == 0);
    pk = sos ? (sfi & 16'hFFFF) : (dfi & 16'hFFFF);
    if (pk == 0) pk = 1;
    unit = pkt ? pk : bs ? ne * nf : fs ? ne : 1;
    xev = '0;
    forever begin
      aev = {ev_half_o, ev_frame_o, ev_last_frame_o, ev_block_o, ev_drop_o};
      chk(aev[4] == xev[4], "R8 half", aev[4], xev[4]);
      chk(aev[3] == xev[3], "R8 frame", aev[3], xev[3]);
      chk(aev[2] == xev[2], "R8 last frame", aev[2], xev[2]);
      chk(aev[1] == xev[1], "R3 block", aev[1], xev[1]);
      chk(aev[0] == xev[0], "R11 drop", aev[0], xev[0]);
      chk(busy_o == (left > 0), "R3 busy", busy_o, left > 0);
      if (left == 0) begin
        chk(out_valid_o == 1'b0, "R3 valid after end", out_valid_o, 0);
        break;
      end
      chk(out_valid_o == (free || pend > 0), free ? "R2 valid" : (pkt ? "R10 valid" : "R9 valid"),
          out_valid_o, free || pend > 0);
      if (out_valid_o) begin
        logic [31:0] er, ew;
        er = exp_addr(sb, sm, esz(dt), sei, sfi, ne, n);
        ew = exp_addr(db, dm, esz(dt), dei, dfi, ne, n);
        chk(rd_addr_o == er, {mtag(sm), " rd addr"}, rd_addr_o, er);
        chk(wr_addr_o == ew, {mtag(dm), " wr addr"}, wr_addr_o, ew);
      end
      if (abort_at >= 0 && n == abort_at) begin
        out_ready_i = 1'b0; sync_req_i = 1'b0; start_i = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0 && out_valid_o == 1'b0, "R12 abort", {busy_o, out_valid_o}, 0);
        @(negedge clk);
        chk({ev_half_o, ev_frame_o, ev_last_frame_o, ev_block_o, ev_drop_o} == '0,
            "R12 no events", {ev_half_o, ev_frame_o, ev_last_frame_o, ev_block_o, ev_drop_o}, 0);
        return;
      end
      out_ready_i = (($urandom % 4) != 0);
      sync_req_i  = (($urandom % 3) == 0);
      hs = out_valid_o && out_ready_i;
      xev = '0;
      if (!free && sync_req_i && pend > 0) xev[0] = 1'b1;
      if (!free && sync_req_i && pend == 0) begin
        pend = (unit < left) ? unit : left;
      end else if (hs) begin
        int e = n % ne;
        int f = n / ne;
        xev[4] = ((ne / 2) != 0) && (e + 1 == ne / 2);
        xev[3] = (e == ne - 1);
        xev[2] = (e == 0) && (f == nf - 1);
        xev[1] = (left == 1);
        n++; left--;
        if (!free) pend--;
      end
      @(negedge clk);
    end
    start_i = 1'b0; out_ready_i = 1'b0; sync_req_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid_o == 1'b0 && busy_o == 1'b0, "R1 valid/busy", {out_valid_o, busy_o}, 0);
    chk({ev_half_o, ev_frame_o, ev_last_frame_o, ev_block_o, ev_drop_o} == '0, "R1 events",
        {ev_half_o, ev_frame_o, ev_last_frame_o, ev_block_o, ev_drop_o}, 0);
    // directed corner cases
    run_block(4, 3, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h1000, 32'h8000, -1);   // R2 R4
    run_block(5, 2, 0, 3, 2, 3, -2, -40, 9, 0, 0, 0, 0, 0, 32'h2000, 32'h3000, -1); // R5
    run_block(0, 3, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h10, 32'h20, -1);       // R7
    run_block(3, 0, 1, 1, 1, 0, 0, 0, 0, 0, 5, 0, 0, 0, 32'h10, 32'h20, -1);       // R7
    run_block(3, 2, 1, 1, 1, 0, 0, 0, 0, 0, 4, 0, 0, 0, 32'h40, 32'h80, -1);       // R9 element
    run_block(4, 3, 1, 1, 3, 0, 2, 0, 6, 0, 9, 1, 0, 0, 32'h40, 32'h80, -1);       // R9 frame
    run_block(3, 3, 3, 1, 1, 0, 0, 0, 0, 0, 9, 1, 1, 0, 32'h40, 32'h80, -1);       // R9 block
    run_block(7, 2, 0, 3, 1, 1, 0, 3, 0, 1, 2, 1, 1, 1, 32'h500, 32'h600, -1);     // R10 src
    run_block(5, 2, 2, 1, 1, 0, 0, 4, 0, 1, 2, 0, 0, 0, 32'h500, 32'h600, -1);     // R10 size 0
    run_block(6, 3, 2, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'hA00, 32'hB00, 7);      // R12 abort
    run_block(2, 2, 2, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'hA00, 32'hB00, -1);     // R12 restart
    run_block(1, 3, 1, 3, 3, 5, -5, 11, -11, 0, 0, 0, 0, 0, 32'hFFFF_FFF0, 32'h0, -1); // R8 wrap
    // constrained random blocks
    for (int i = 0; i < 60; i++) begin
      int ne = $urandom_range(1, 9);
      int nf = $urandom_range(1, 4);
      bit pkt = ($urandom % 4) == 0;
      bit sos = $urandom % 2;
      int sfi = int'($urandom_range(0, 128)) - 64;
      int dfi = int'($urandom_range(0, 128)) - 64;
      int ssel = (($urandom % 3) == 0) ? 0 : $urandom_range(1, 127);
      int ab = (($urandom % 8) == 0) ? $urandom_range(0, ne * nf - 1) : -1;
      if (pkt && sos) sfi = $urandom_range(1, 6);
      if (pkt && !sos) dfi = $urandom_range(1, 6);
      run_block(ne, nf, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                int'($urandom_range(0, 128)) - 64, int'($urandom_range(0, 128)) - 64,
                sfi, dfi, pkt, ssel, $urandom % 2, $urandom % 2, sos,
                $urandom, $urandom, ab);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule